// File: doc/BRIEF.md
# Raster Sync Timing Generator

This block drives the scan timing for a 640 by 480 display refreshed at 60 Hz. It runs from a 100 MHz system clock and advances a pixel position once every four clocks. The pixel-rate strobe goes out on a port, so that the colour logic downstream can pace itself to the same rhythm. A column counter and a row counter track the beam position. Both go out undelayed as the pixel coordinates. Point (0,0) is the top-left visible pixel and (639,479) is the bottom-right one.

From the two counts the block decodes three things: an active-low line sync, an active-low frame sync, and a flag that is true only inside the visible window. The two syncs are registered and then delayed by two more clock stages, so they line up with the latency of a video DAC. A composite sync is formed from the two delayed syncs. The timing regions (visible span, front porch, pulse and back porch on each axis), the divide ratio and the extra delay are all parameters.

Top module: `vga_raster_sync`

## Requirements
- R1: `pix_strobe` is high for exactly one clock in every 2**DIV_BITS clocks. It is high on the clock where the free-running divider holds its all-ones value, which is the (2**DIV_BITS)-th clock after reset is released.
- R2: `pix_x` advances by one only in the clock after a `pix_strobe`. It counts 0 to H_TOTAL-1 (H_TOTAL = H_ACTIVE+H_FRONT+H_PULSE+H_BACK, 800 by default) and then returns to 0.
- R3: `pix_y` advances by one only when a strobe finds `pix_x` at H_TOTAL-1. It counts 0 to V_TOTAL-1 (525 by default) and then returns to 0.
- R4: `line_sync_n` is low exactly when `pix_x`, three clocks earlier, lay in H_ACTIVE+H_FRONT to H_ACTIVE+H_FRONT+H_PULSE-1 (656 to 751 by default). It is high otherwise.
- R5: `frame_sync_n` is low exactly when `pix_y`, three clocks earlier, lay in V_ACTIVE+V_FRONT to V_ACTIVE+V_FRONT+V_PULSE-1 (490 and 491 by default).
- R6: `comp_sync_n` is low whenever either delayed sync output is low, and high otherwise.
- R7: `video_on` is high in the same clock as the coordinates exactly when `pix_x` < H_ACTIVE and `pix_y` < V_ACTIVE.
- R8: A synchronous active-high `rst` clears the divider and both counters. It also sets every sync stage to its inactive high level. In the clock after reset, both coordinates are 0, the strobe is low and all three syncs are high.
- R9: With the default parameters a line lasts 3200 clocks, and `line_sync_n` stays low for 384 consecutive clocks in each line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 100 MHz |
| rst | input | 1 | Synchronous active-high reset |
| line_sync_n | output | 1 | Delayed active-low horizontal sync |
| frame_sync_n | output | 1 | Delayed active-low vertical sync |
| comp_sync_n | output | 1 | Active-low composite of both delayed syncs |
| video_on | output | 1 | High inside the visible window |
| pix_strobe | output | 1 | One-clock pixel-rate enable |
| pix_x | output | COORD_W | Current column count |
| pix_y | output | COORD_W | Current row count |

## Verification
The bench builds two copies of the block. The first uses a reduced raster: 8+2+3+2 columns by 4+1+2+1 rows, with the default divide by four. A full frame then takes only 480 clocks, so every strobe, every wrap of both axes, both sync windows, the blanking decode and a reset in mid-frame can be compared cycle by cycle against a reference computed in the bench. The second copy uses the default 640 by 480 values. There the bench measures the real line period, the real line-sync pulse width and the 799-to-0 column wrap; a full default frame would need far more clocks than the run allows.

// File: rtl/vga_timing_pkg.sv
package vga_timing_pkg;

    // Pair of active-low sync levels carried together through the delay line.
    typedef struct packed {
        logic line_n;
        logic frame_n;
    } sync_pair_t;

    localparam sync_pair_t SYNC_IDLE = '{line_n: 1'b1, frame_n: 1'b1};

    // True when pos falls in [start, start+len-1].
    function automatic logic in_window(input int pos, input int start, input int len);
        return (pos >= start) && (pos < start + len);
    endfunction

endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int DIV_BITS = 2
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    logic [DIV_BITS-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) phase <= '0;
        else     phase <= phase + 1'b1;
    end

    assign tick = &phase;
endmodule

// File: rtl/axis_counter.sv
module axis_counter #(
    parameter int MODULUS = 800,
    parameter int W       = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [W-1:0] value,
    output logic         at_end
);
    localparam logic [W-1:0] LAST = W'(MODULUS - 1);

    assign at_end = (value == LAST);

    always_ff @(posedge clk) begin
        if (rst)
            value <= '0;
        else if (step)
            value <= at_end ? '0 : value + 1'b1;
    end
endmodule

// File: rtl/sync_delay_line.sv
module sync_delay_line
    import vga_timing_pkg::*;
#(
    parameter int STAGES = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  sync_pair_t din,
    output sync_pair_t dout
);
    sync_pair_t stage [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= SYNC_IDLE;
                else     stage[i] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage[i] <= SYNC_IDLE;
                else     stage[i] <= stage[i-1];
            end
        end
    end

    assign dout = stage[STAGES-1];
endmodule

// File: rtl/vga_raster_sync.sv
module vga_raster_sync
    import vga_timing_pkg::*;
#(
    parameter int H_ACTIVE  = 640,
    parameter int H_FRONT   = 16,
    parameter int H_PULSE   = 96,
    parameter int H_BACK    = 48,
    parameter int V_ACTIVE  = 480,
    parameter int V_FRONT   = 10,
    parameter int V_PULSE   = 2,
    parameter int V_BACK    = 33,
    parameter int DIV_BITS  = 2,
    parameter int DAC_DELAY = 2,
    parameter int COORD_W   = 10
) (
    input  logic               clk,
    input  logic               rst,
    output logic               line_sync_n,
    output logic               frame_sync_n,
    output logic               comp_sync_n,
    output logic               video_on,
    output logic               pix_strobe,
    output logic [COORD_W-1:0] pix_x,
    output logic [COORD_W-1:0] pix_y
);
    localparam int H_TOTAL  = H_ACTIVE + H_FRONT + H_PULSE + H_BACK;
    localparam int V_TOTAL  = V_ACTIVE + V_FRONT + V_PULSE + V_BACK;
    localparam int H_SSTART = H_ACTIVE + H_FRONT;
    localparam int V_SSTART = V_ACTIVE + V_FRONT;
    localparam int STAGES   = 1 + DAC_DELAY;

    logic       tick, h_end, v_end;
    sync_pair_t sync_now, sync_late;

    tick_divider #(.DIV_BITS(DIV_BITS)) u_div (
        .clk(clk), .rst(rst), .tick(tick)
    );

    axis_counter #(.MODULUS(H_TOTAL), .W(COORD_W)) u_hcnt (
        .clk(clk), .rst(rst), .step(tick), .value(pix_x), .at_end(h_end)
    );

    axis_counter #(.MODULUS(V_TOTAL), .W(COORD_W)) u_vcnt (
        .clk(clk), .rst(rst), .step(tick & h_end), .value(pix_y), .at_end(v_end)
    );

    always_comb begin
        sync_now.line_n  = ~in_window(int'(pix_x), H_SSTART, H_PULSE);
        sync_now.frame_n = ~in_window(int'(pix_y), V_SSTART, V_PULSE);
    end

    sync_delay_line #(.STAGES(STAGES)) u_dly (
        .clk(clk), .rst(rst), .din(sync_now), .dout(sync_late)
    );

    assign line_sync_n  = sync_late.line_n;
    assign frame_sync_n = sync_late.frame_n;
    assign comp_sync_n  = sync_late.line_n & sync_late.frame_n;
    assign video_on     = (int'(pix_x) < H_ACTIVE) && (int'(pix_y) < V_ACTIVE);
    assign pix_strobe   = tick;

    logic unused_v_end;
    assign unused_v_end = v_end;
endmodule

// File: rtl/vga_raster_sync_chk.sv
module vga_raster_sync_chk #(
    parameter int H_ACTIVE = 640,
    parameter int H_FRONT  = 16,
    parameter int H_PULSE  = 96,
    parameter int H_BACK   = 48,
    parameter int V_ACTIVE = 480,
    parameter int V_FRONT  = 10,
    parameter int V_PULSE  = 2,
    parameter int V_BACK   = 33,
    parameter int COORD_W  = 10
) (
    input logic               clk,
    input logic               rst,
    input logic               line_sync_n,
    input logic               frame_sync_n,
    input logic               pix_strobe,
    input logic [COORD_W-1:0] pix_x,
    input logic [COORD_W-1:0] pix_y
);
    localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_PULSE + H_BACK;
    localparam int H_LO    = H_ACTIVE + H_FRONT;
    localparam int V_LO    = V_ACTIVE + V_FRONT;

    assert_strobe_single_R1: assert property (@(posedge clk) disable iff (rst)
        pix_strobe |=> !pix_strobe);

    assert_x_holds_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(pix_strobe) |-> $stable(pix_x));

    assert_y_holds_R3: assert property (@(posedge clk) disable iff (rst)
        !($past(pix_strobe) && (int'($past(pix_x)) == H_TOTAL - 1)) |-> $stable(pix_y));

    assert_line_sync_window_R4: assert property (@(posedge clk) disable iff (rst)
        !line_sync_n |-> (int'($past(pix_x, 3)) >= H_LO && int'($past(pix_x, 3)) < H_LO + H_PULSE));

    assert_frame_sync_window_R5: assert property (@(posedge clk) disable iff (rst)
        !frame_sync_n |-> (int'($past(pix_y, 3)) >= V_LO && int'($past(pix_y, 3)) < V_LO + V_PULSE));

    assert_reset_state_R8: assert property (@(posedge clk)
        rst |=> (pix_x == '0 && pix_y == '0 && line_sync_n && frame_sync_n && !pix_strobe));
endmodule

bind vga_raster_sync vga_raster_sync_chk #(
    .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_PULSE(H_PULSE), .H_BACK(H_BACK),
    .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_PULSE(V_PULSE), .V_BACK(V_BACK),
    .COORD_W(COORD_W)
) u_chk (
    .clk(clk), .rst(rst), .line_sync_n(line_sync_n), .frame_sync_n(frame_sync_n),
    .pix_strobe(pix_strobe), .pix_x(pix_x), .pix_y(pix_y)
);

// File: tb/vga_raster_sync_tb.sv
`timescale 1ns/1ps
module vga_raster_sync_tb;
    localparam int HA = 8, HF = 2, HS = 3, HB = 2;
    localparam int VA = 4, VF = 1, VS = 2, VB = 1;
    localparam int HT = HA + HF + HS + HB;
    localparam int VT = VA + VF + VS + VB;
    localparam int DV = 4;
    localparam int FRAME = HT * VT * DV;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic       s_hs, s_vs, s_cs, s_vid, s_tick;
    logic [9:0] s_x, s_y;
    logic       b_hs, b_vs, b_cs, b_vid, b_tick;
    logic [9:0] b_x, b_y;

    vga_raster_sync #(
        .H_ACTIVE(HA), .H_FRONT(HF), .H_PULSE(HS), .H_BACK(HB),
        .V_ACTIVE(VA), .V_FRONT(VF), .V_PULSE(VS), .V_BACK(VB)
    ) u_dut (
        .clk(clk), .rst(rst), .line_sync_n(s_hs), .frame_sync_n(s_vs),
        .comp_sync_n(s_cs), .video_on(s_vid), .pix_strobe(s_tick),
        .pix_x(s_x), .pix_y(s_y)
    );

    vga_raster_sync u_dut_vga (
        .clk(clk), .rst(rst), .line_sync_n(b_hs), .frame_sync_n(b_vs),
        .comp_sync_n(b_cs), .video_on(b_vid), .pix_strobe(b_tick),
        .pix_x(b_x), .pix_y(b_y)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int ex(input int n); return (n / DV) % HT; endfunction
    function automatic int ey(input int n); return (n / (DV * HT)) % VT; endfunction
    function automatic int lag(input int n); return (n < 3) ? 0 : n - 3; endfunction
    function automatic int exp_hs(input int n);
        int x = ex(lag(n));
        return (x >= HA + HF && x < HA + HF + HS) ? 0 : 1;
    endfunction
    function automatic int exp_vs(input int n);
        int y = ey(lag(n));
        return (y >= VA + VF && y < VA + VF + VS) ? 0 : 1;
    endfunction

    task automatic apply_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic test_reset_state();
        // R8: outputs while held in reset
        check("R8", "x", int'(s_x), 0);
        check("R8", "y", int'(s_y), 0);
        check("R8", "strobe", int'(s_tick), 0);
        check("R8", "line_sync", int'(s_hs), 1);
        check("R8", "frame_sync", int'(s_vs), 1);
        check("R8", "comp_sync", int'(s_cs), 1);
        check("R8", "big x", int'(b_x), 0);
    endtask

    // Cycle-by-cycle comparison against the reference for a number of clocks.
    task automatic test_model_run(input int cycles);
        int bad = 0;
        for (int n = 1; n <= cycles; n++) begin
            int e0 = errors;
            @(negedge clk);
            check("R1", "strobe", int'(s_tick), (n % DV == DV - 1) ? 1 : 0);
            check("R2", "x", int'(s_x), ex(n));
            check("R3", "y", int'(s_y), ey(n));
            check("R4", "line_sync", int'(s_hs), exp_hs(n));
            check("R5", "frame_sync", int'(s_vs), exp_vs(n));
            check("R6", "comp_sync", int'(s_cs), exp_hs(n) & exp_vs(n));
            check("R7", "video_on", int'(s_vid), (ex(n) < HA && ey(n) < VA) ? 1 : 0);
            if (errors != e0) bad++;
            if (bad > 5) break;
        end
    endtask

    task automatic test_midframe_reset();
        repeat (FRAME / 2 + 7) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        // R8: one clock after reset is applied
        check("R8", "x after reset", int'(s_x), 0);
        check("R8", "y after reset", int'(s_y), 0);
        check("R8", "line_sync after reset", int'(s_hs), 1);
        check("R8", "frame_sync after reset", int'(s_vs), 1);
        @(negedge clk);
        rst = 1'b0;
        test_model_run(FRAME + 20);
    endtask

    task automatic test_default_line();
        int waited = 0, low = 0, period = 0, prev_x;
        bit wrap_seen = 0;
        apply_reset();
        while (b_hs !== 1'b0 && waited < 8000) begin
            @(negedge clk); waited++;
        end
        check("R9", "line sync seen", (b_hs === 1'b0) ? 1 : 0, 1);
        prev_x = int'(b_x);
        while (b_hs === 1'b0 && low < 4000) begin
            low++; period++;
            @(negedge clk);
        end
        check("R9", "line sync low clocks", low, 384);
        while (!(b_hs === 1'b0) && period < 8000) begin
            period++;
            @(negedge clk);
            if (prev_x == 799 && int'(b_x) != 799) begin
                wrap_seen = 1;
                check("R2", "column wrap", int'(b_x), 0);
            end
            prev_x = int'(b_x);
        end
        check("R9", "line period clocks", period, 3200);
        check("R2", "wrap observed", int'(wrap_seen), 1);
        check("R7", "blank at x 640+ on row 0", int'(b_vid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset_state();
        rst = 1'b0;
        test_model_run(3 * FRAME);
        test_midframe_reset();
        test_default_line();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule